// File: doc/BRIEF.md
# Four-Bit Framed Pattern Recognizer

The block watches a one-bit serial stream and cuts it into consecutive, non-overlapping groups of four accepted bits. On the fourth bit of each group it raises `hit` for that one cycle if the group, read in arrival order, was `1010` or `0110`. On every other bit it holds `hit` low. A group never shares bits with its neighbour, and the block returns to its initial state after each fourth bit.

The recognizer is a state-minimized Mealy machine, not a shift register. The two target strings share the suffix `10`. Every group prefix that can still match on that suffix is therefore merged into one state per bit position, and every prefix that can no longer match is merged into one dead state per position. This leaves seven states in a three-bit register.

A qualifier `bit_vld` marks the cycles that carry a stream bit. A synchronous clear `frame_clr` realigns the group boundary without a full reset. The asynchronous active-low reset is released through a small synchronizer.

Top module: `rec_framed_match`

## Requirements
- R1: While reset is asserted, and until its synchronized release, `hit` is 0 for any input. The first accepted bit after release is the first bit of a group.
- R2: On the fourth accepted bit of a group, `hit` is 1 exactly when the group's bits, first-arrived bit written leftmost, are `1010` or `0110`. Otherwise `hit` is 0.
- R3: On the first, second and third accepted bits of every group, `hit` is 0.
- R4: Groups do not overlap. The accepted bit that follows a fourth bit is always the first bit of a new group.
- R5: In a cycle with `bit_vld` low, `hit` is 0, `bit_in` is ignored, and the position within the group and the partial group are held.
- R6: In a cycle with `frame_clr` high, `hit` is 0 and the bit is discarded. The next accepted bit starts a new group.
- R7: The state register is three bits wide and only ever holds one of seven legal codes. All sixteen possible groups are classified correctly by the merged states.
- R8: The input `0010 0110 1100 1010 0011`, sent with no gaps, gives `hit` = `0000 0001 0000 0001 0000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_clr | input | 1 | Synchronous clear: discard the partial group and restart framing |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | High on the fourth bit of a matching group (Mealy output) |

## Verification
The bench builds the block with `SYNC_STAGES` = 2, the default two-stage reset release. That value makes the reset window short enough to probe `hit` before and after release. A long random stream then runs with idle gaps and rare clears, so groups land at every alignment relative to `bit_vld` and `frame_clr`. Directed phases send all sixteen group values, the example stream, a group split by idle cycles, and a clear in mid-group. Together these reach every merged state and every dead state.

// File: rtl/rec_pkg.sv
`timescale 1ns/1ps
package rec_pkg;
  localparam int GROUP_LEN = 4;
  localparam int ST_W      = 3;

  // Merged states: one live and one dead path per position (position 0 splits by first bit)
  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,  // start of group
    ST_LEAD1 = 3'd1,  // first bit was 1, needs 0 next
    ST_LEAD0 = 3'd2,  // first bit was 0, needs 1 next
    ST_MID   = 3'd3,  // two bits ok, needs 1 then 0
    ST_TAIL  = 3'd4,  // three bits ok, needs 0
    ST_DEAD2 = 3'd5,  // two bits seen, no match possible
    ST_DEAD3 = 3'd6   // three bits seen, no match possible
  } rec_state_e;
endpackage

// File: rtl/rec_rst_sync.sv
`timescale 1ns/1ps
module rec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rec_next_state.sv
`timescale 1ns/1ps
module rec_next_state
  import rec_pkg::*;
(
  input  rec_state_e cur_st,
  input  logic       frame_clr,
  input  logic       bit_vld,
  input  logic       bit_in,
  output rec_state_e nxt_st,
  output logic       st_en,
  output logic       hit
);
  logic       advance;
  rec_state_e step_st;

  assign advance = bit_vld & ~frame_clr;

  always_comb begin
    unique case (cur_st)
      ST_IDLE:  step_st = bit_in ? ST_LEAD1 : ST_LEAD0;
      ST_LEAD1: step_st = bit_in ? ST_DEAD2 : ST_MID;
      ST_LEAD0: step_st = bit_in ? ST_MID   : ST_DEAD2;
      ST_MID:   step_st = bit_in ? ST_TAIL  : ST_DEAD3;
      ST_DEAD2: step_st = ST_DEAD3;
      ST_TAIL:  step_st = ST_IDLE;
      ST_DEAD3: step_st = ST_IDLE;
      default:  step_st = ST_IDLE;
    endcase
  end

  always_comb begin
    st_en  = frame_clr | bit_vld;
    nxt_st = frame_clr ? ST_IDLE : step_st;
  end

  assign hit = advance & (cur_st == ST_TAIL) & ~bit_in;
endmodule

// File: rtl/rec_state_reg.sv
`timescale 1ns/1ps
module rec_state_reg
  import rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  rec_state_e d,
  output rec_state_e q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= ST_IDLE;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/rec_framed_match.sv
`timescale 1ns/1ps
module rec_framed_match
  import rec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);
  logic       rst_sync_n;
  logic       st_en;
  logic       hit_raw;
  rec_state_e cur_st;
  rec_state_e nxt_st;

  rec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rec_next_state u_nsl (
    .cur_st    (cur_st),
    .frame_clr (frame_clr),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .nxt_st    (nxt_st),
    .st_en     (st_en),
    .hit       (hit_raw)
  );

  rec_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (st_en),
    .d     (nxt_st),
    .q     (cur_st)
  );

  assign hit = hit_raw & rst_sync_n;
endmodule

module rec_framed_match_chk
  import rec_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       frame_clr,
  input logic       bit_vld,
  input logic       hit,
  input rec_state_e cur_st
);
  logic [1:0] pos_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pos_q <= 2'd0;
    end else if (frame_clr) begin
      pos_q <= 2'd0;
    end else if (bit_vld) begin
      pos_q <= pos_q + 2'd1;
    end
  end

  // R3
  hit_pos_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (pos_q == 2'd3));

  // R4
  wrap_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_vld && !frame_clr && pos_q == 2'd3) |=> (cur_st == ST_IDLE));

  // R5
  idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bit_vld |-> !hit);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bit_vld && !frame_clr) |=> $stable(cur_st));

  // R6
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_clr |=> (cur_st == ST_IDLE));

  // R6
  clr_nohit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_clr |-> !hit);

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cur_st != rec_state_e'(3'd7));

  // R1
  always_comb begin
    if (!rst_sync_n) begin
      rst_quiet_chk: assert (!hit);
    end
  end
endmodule

bind rec_framed_match rec_framed_match_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .frame_clr  (frame_clr),
  .bit_vld    (bit_vld),
  .hit        (hit),
  .cur_st     (cur_st)
);

// File: tb/sim_rec_framed_match.sv
`timescale 1ns/1ps
module sim_rec_framed_match;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clr = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic hit;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [2:0] m_sh = 3'd0;
  int         m_cnt = 0;

  always #2.5 clk = ~clk;

  rec_framed_match #(.SYNC_STAGES(SYNC_STAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr),
    .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit)
  );

  function automatic logic model_hit(logic v, logic b, logic c);
    logic [3:0] grp;
    grp = {m_sh, b};
    return v && !c && (m_cnt == 3) && (grp == 4'b1010 || grp == 4'b0110);
  endfunction

  task automatic model_update(logic v, logic b, logic c);
    if (c) begin
      m_cnt = 0;
    end else if (v) begin
      m_sh  = {m_sh[1:0], b};
      m_cnt = (m_cnt + 1) % 4;
    end
  endtask

  task automatic cmp(logic exp, string tag);
    vectors++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected=%b (vector %0d)", tag, hit, exp, vectors);
    end
  endtask

  // drive at negedge, sample 1 ns later, well before the next rising edge
  task automatic step(logic v, logic b, logic c, string tag);
    logic exp;
    @(negedge clk);
    bit_vld = v; bit_in = b; frame_clr = c;
    #1;
    exp = model_hit(v, b, c);
    cmp(exp, tag);
    model_update(v, b, c);
  endtask

  task automatic send_group(logic [3:0] g, string tag);
    for (int i = 3; i >= 0; i--) step(1'b1, g[i], 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [19:0] ex_in;
    logic [19:0] ex_z;
    void'($urandom(32'd1234));

    // R1: hit quiet while reset held, even with a matching group presented
    for (int i = 0; i < 2; i++) begin
      for (int k = 3; k >= 0; k--) begin
        @(negedge clk);
        bit_vld = 1'b1; bit_in = (4'b1010 >> k) & 1'b1; frame_clr = 1'b0;
        #1; cmp(1'b0, "R1");
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < SYNC_STAGES + 2; i++) step(1'b0, 1'b1, 1'b0, "R1");
    m_cnt = 0; m_sh = 3'd0;
    send_group(4'b1010, "R1");

    // R7 / R2: every group value
    for (int g = 0; g < 16; g++) send_group(4'(g), "R7");

    // R8: example stream with explicit expected outputs
    ex_in = 20'b0010_0110_1100_1010_0011;
    ex_z  = 20'b0000_0001_0000_0001_0000;
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      bit_vld = 1'b1; bit_in = ex_in[i]; frame_clr = 1'b0;
      #1; cmp(ex_z[i], "R8");
      model_update(1'b1, ex_in[i], 1'b0);
    end

    // R5: matching group split by idle cycles with inverted data
    step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");

    // R6: clear mid-group, then a fresh group matches on its own fourth bit
    step(1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");
    send_group(4'b0110, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");

    // R4: realignment check, a shifted 1010 straddling groups must not hit
    send_group(4'b0001, "R4");
    send_group(4'b0101, "R4");
    send_group(4'b1010, "R4");

    // R2 / R3 / R4: constrained random stream
    for (int i = 0; i < 12000; i++) begin
      logic v, b, c;
      v = ($urandom % 100) < 85;
      b = $urandom % 2;
      c = ($urandom % 200) == 0;
      if (m_cnt == 3 && v && !c) step(v, b, c, "R2");
      else step(v, b, c, "R3");
    end

    finish_run();
  end
endmodule